// File: doc/BRIEF.md
# Timer Tick Enable Generator

This block turns one base clock into a set of per-channel tick-enable pulses for a five-channel PWM timer. Two shared 8-bit prescalers sit at the front. Prescaler 0 serves channels 0 and 1, and prescaler 1 serves channels 2, 3 and 4. Each prescaler divides the base clock by its programmed value plus one. Each channel then applies its own power-of-two divider to the prescaled tick. Certain select codes replace that divider with an external tick input that is synchronised and edge-detected.

A small write/read configuration port holds the two prescaler values and the five 4-bit select fields. A new value written to a register can be read back at once. It reaches the tick logic only at the next wrap of the owning prescaler, so a reprogramming never produces an early or partial pulse. Every output is an enable in the base clock domain. No derived clocks exist. A downstream counter advances in each cycle where its tick bit is high.

Top module: `pwm_tick_gen`

## Requirements
- R1: Writing address 0 stores prescaler 0 from data bits [7:0] and prescaler 1 from bits [15:8]. Reading address 0 returns them in the same positions, with bits [31:16] as 0.
- R2: Writing address 1 stores a 4-bit select field for channel c at bits [4c+3:4c]. Reading address 1 returns the five fields, with bits [31:20] as 0.
- R3: A prescaler holding value p produces one prescaled tick every p+1 base clock cycles.
- R4: A new prescaler value or select code is used only from the next wrap of the owning prescaler. Ticks already under way finish with the old setting.
- R5: For a non-external code s, the channel ticks once every 2^min(s+DIV_BASE,4) prescaled ticks, with DIV_BASE 0 by default. Every such tick coincides with a wrap of its prescaler.
- R6: Channels 0 and 1 use prescaler 0 and external input bit 0. Channels 2 to 4 use prescaler 1 and external input bit 1.
- R7: A code whose bit is set in EXT_MASK (default: code 4 only) makes the channel pulse for exactly one cycle per rising edge of its external input. The pulse is visible two base clock edges after the change. A falling edge gives no pulse.
- R8: After reset both registers read 0, and every channel ticks in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Register select: 0 prescalers, 1 channel selects |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the addressed register |
| ext_tick_i | input | 2 | Asynchronous external tick sources, one per group |
| tick_o | output | 5 | Per-channel tick-enable pulses |

## Verification
The assertions check four properties on every cycle. A divider tick only appears in a cycle where its prescaler wraps. A detected external edge never lasts two cycles. A register write lands in the following cycle. The active prescaler value moves only on a wrap. The exact tick periods for mixed prescaler and code combinations can only be shown by the bench's scenarios. The same holds for the deferred reload after a mid-count write, the two-edge latency of the external path, and the clamp of large codes to divide-by-16.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  // log2 of the channel divider for a select code, clamped to the largest division
  function automatic int div_log(input int code, input int base, input int max_log);
    int k;
    k = code + base;
    if (k > max_log) k = max_log;
    return k;
  endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int NUM_CH = 5,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [2*PSC_W-1:0]      psc_o,
  output logic [NUM_CH*SEL_W-1:0] sel_o
);
  localparam int PSC_BITS = 2 * PSC_W;
  localparam int SEL_BITS = NUM_CH * SEL_W;

  logic [PSC_BITS-1:0] psc_q;
  logic [SEL_BITS-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      if (!addr_i) psc_q <= wdata_i[PSC_BITS-1:0];
      else         sel_q <= wdata_i[SEL_BITS-1:0];
    end
  end

  assign rdata_o = addr_i ? DATA_W'(sel_q) : DATA_W'(psc_q);
  assign psc_o   = psc_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/pwm_psc_stage.sv
module pwm_psc_stage #(
  parameter int PSC_W   = 8,
  parameter int MAX_LOG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PSC_W-1:0]   psc_i,
  output logic               wrap_o,
  output logic [MAX_LOG-1:0] div_cnt_o,
  output logic [PSC_W-1:0]   act_o
);
  logic [PSC_W-1:0]   cnt_q, act_q;
  logic [MAX_LOG-1:0] div_q;

  assign wrap_o = (cnt_q == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      div_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      act_q <= psc_i;       // new value only at wrap
      div_q <= div_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_cnt_o = div_q;
  assign act_o     = act_q;
endmodule

// File: rtl/pwm_ext_sync.sv
module pwm_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[1:0], async_i};
  end

  assign rise_o = s_q[1] & ~s_q[2];
endmodule

// File: rtl/pwm_ch_sel.sv
module pwm_ch_sel
  import pwm_tick_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int DIV_BASE = 0,
  parameter int MAX_LOG  = 4,
  parameter int SEL_N    = 16,
  parameter logic [SEL_N-1:0] EXT_MASK = 16'h0010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               wrap_i,
  input  logic [MAX_LOG-1:0] div_cnt_i,
  input  logic               ext_rise_i,
  output logic               tick_o,
  output logic               ext_o
);
  logic [SEL_W-1:0]   sel_act_q;
  logic [MAX_LOG-1:0] need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_act_q <= '0;
    else if (wrap_i) sel_act_q <= sel_i;
  end

  always_comb begin
    int k;
    k    = div_log(int'(sel_act_q), DIV_BASE, MAX_LOG);
    need = MAX_LOG'((32'd1 << k) - 32'd1);
  end

  assign ext_o  = EXT_MASK[sel_act_q];
  assign tick_o = ext_o ? ext_rise_i
                        : (wrap_i && ((div_cnt_i & need) == need));
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int NUM_CH   = 5,
  parameter int PSC_W    = 8,
  parameter int SEL_W    = 4,
  parameter int DIV_BASE = 0,
  parameter int MAX_LOG  = 4,
  parameter int SPLIT    = 2,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic [1:0]        ext_tick_i,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int NUM_GRP = 2;
  localparam int SEL_N   = 1 << SEL_W;

  logic [NUM_GRP*PSC_W-1:0]  psc_q;
  logic [NUM_CH*SEL_W-1:0]   sel_q;
  logic [NUM_GRP-1:0]        grp_wrap;
  logic [NUM_GRP-1:0]        ext_rise;
  logic [NUM_GRP*PSC_W-1:0]  grp_act;
  logic [NUM_GRP*MAX_LOG-1:0] grp_div;
  logic [NUM_CH-1:0]         ch_ext;

  pwm_cfg_regs #(
    .NUM_CH(NUM_CH), .PSC_W(PSC_W), .SEL_W(SEL_W), .DATA_W(32)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .psc_o(psc_q), .sel_o(sel_q)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pwm_psc_stage #(.PSC_W(PSC_W), .MAX_LOG(MAX_LOG)) u_psc (
      .clk_i, .rst_ni,
      .psc_i(psc_q[g*PSC_W +: PSC_W]),
      .wrap_o(grp_wrap[g]),
      .div_cnt_o(grp_div[g*MAX_LOG +: MAX_LOG]),
      .act_o(grp_act[g*PSC_W +: PSC_W])
    );
    pwm_ext_sync u_sync (
      .clk_i, .rst_ni, .async_i(ext_tick_i[g]), .rise_o(ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int G = (c < SPLIT) ? 0 : 1;
    pwm_ch_sel #(
      .SEL_W(SEL_W), .DIV_BASE(DIV_BASE), .MAX_LOG(MAX_LOG),
      .SEL_N(SEL_N), .EXT_MASK(EXT_MASK)
    ) u_sel (
      .clk_i, .rst_ni,
      .sel_i(sel_q[c*SEL_W +: SEL_W]),
      .wrap_i(grp_wrap[G]),
      .div_cnt_i(grp_div[G*MAX_LOG +: MAX_LOG]),
      .ext_rise_i(ext_rise[G]),
      .tick_o(tick_o[c]),
      .ext_o(ch_ext[c])
    );
  end
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
  parameter int NUM_CH  = 5,
  parameter int NUM_GRP = 2,
  parameter int PSC_W   = 8,
  parameter int SPLIT   = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic                     cfg_addr_i,
  input logic [31:0]              cfg_wdata_i,
  input logic [NUM_CH-1:0]        tick_o,
  input logic [NUM_GRP-1:0]       grp_wrap,
  input logic [NUM_GRP-1:0]       ext_rise,
  input logic [NUM_CH-1:0]        ch_ext,
  input logic [NUM_GRP*PSC_W-1:0] psc_q,
  input logic [NUM_GRP*PSC_W-1:0] grp_act
);
  assert_cfg_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_addr_i) |=> (psc_q == $past(cfg_wdata_i[NUM_GRP*PSC_W-1:0])));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assert_reload_at_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grp_wrap[g] |=> $stable(grp_act[g*PSC_W +: PSC_W]));
    assert_ext_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_rise[g] |=> !ext_rise[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int G = (c < SPLIT) ? 0 : 1;
    assert_tick_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[c] && !ch_ext[c]) |-> grp_wrap[G]);
  end
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
  .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .PSC_W(PSC_W), .SPLIT(SPLIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .tick_o(tick_o), .grp_wrap(grp_wrap),
  .ext_rise(ext_rise), .ch_ext(ch_ext), .psc_q(psc_q), .grp_act(grp_act)
);

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;
  localparam int CLK_P  = 10;
  localparam int NCH    = 5;
  localparam int NVEC   = 4;

  localparam logic [15:0] VEC_PSC [NVEC] = '{16'h0000, 16'h0002, 16'h0400, 16'h0101};
  localparam logic [19:0] VEC_SEL [NVEC] = '{20'h00000, 20'h70231, 20'h23103, 20'h1502F};
  localparam int VEC_PER [NVEC][NCH] = '{
    '{1, 1, 1, 1, 1},
    '{6, 24, 4, 1, 16},
    '{8, 1, 10, 40, 20},
    '{32, 8, 2, 32, 4}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic            cfg_addr_i = 1'b0;
  logic [31:0]     cfg_wdata_i = '0;
  logic [31:0]     cfg_rdata_o;
  logic [1:0]      ext_tick_i = '0;
  logic [NCH-1:0]  tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_t [NCH];
  int ivl [NCH];

  pwm_tick_gen dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .cfg_rdata_o, .ext_tick_i, .tick_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    for (int c = 0; c < NCH; c++) begin
      if (tick_o[c]) begin
        ivl[c] = cyc - last_t[c];
        last_t[c] = cyc;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic a, input logic [31:0] exp);
    cfg_addr_i = a;
    #1;
    chk(req, cfg_rdata_o, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin last_t[c] = 0; ivl[c] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 tick all channels", 32'(tick_o), 32'h1F);
    rd_chk("R8 reg0 reset", 1'b0, 32'h0);
    rd_chk("R8 reg1 reset", 1'b1, 32'h0);

    // R1 R2 field widths on readback
    wr(1'b0, 32'hFFFF_FFFF);
    rd_chk("R1 reg0 readback", 1'b0, 32'h0000_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);
    rd_chk("R2 reg1 readback", 1'b1, 32'h000F_FFFF);

    // R3 R5 R6 period table
    for (int v = 0; v < NVEC; v++) begin
      wr(1'b0, 32'(VEC_PSC[v]));
      wr(1'b1, 32'(VEC_SEL[v]));
      repeat (600) @(negedge clk_i);
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R3 R5 R6 vec%0d ch%0d period", v, c), 32'(ivl[c]), 32'(VEC_PER[v][c]));
    end

    // R4 deferred prescaler reload
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h9);
    repeat (40) @(negedge clk_i);
    do @(negedge clk_i); while (!tick_o[0]);
    cfg_we_i = 1'b1; cfg_addr_i = 1'b0; cfg_wdata_i = 32'h0;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    rd_chk("R4 R1 new value readable at once", 1'b0, 32'h0);
    chk("R4 old count continues", 32'(tick_o[0]), 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk("R4 old count continues", 32'(tick_o[0]), 32'h0);
    end
    @(negedge clk_i);
    chk("R4 tick at old wrap", 32'(tick_o[0]), 32'h1);
    @(negedge clk_i);
    chk("R4 new value after wrap", 32'(tick_o[0]), 32'h1);

    // R7 R6 external path: ch0 and ch2 on code 4
    wr(1'b1, 32'h0000_0404);
    repeat (5) @(negedge clk_i);
    chk("R7 idle no ext pulse", 32'({tick_o[2], tick_o[0]}), 32'h0);
    ext_tick_i[0] = 1'b1;
    @(negedge clk_i);
    chk("R7 not yet after one edge", 32'(tick_o[0]), 32'h0);
    @(negedge clk_i);
    chk("R7 pulse after two edges", 32'(tick_o[0]), 32'h1);
    chk("R6 ext0 not seen by ch2", 32'(tick_o[2]), 32'h0);
    chk("R6 ch1 keeps dividing", 32'(tick_o[1]), 32'h1);
    @(negedge clk_i);
    chk("R7 pulse is one cycle", 32'(tick_o[0]), 32'h0);
    ext_tick_i[0] = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk_i);
        if (tick_o[0]) seen++;
      end
      chk("R7 falling edge no pulse", 32'(seen), 32'h0);
    end
    ext_tick_i[1] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 R7 ext1 drives ch2", 32'(tick_o[2]), 32'h1);
    chk("R6 ext1 not seen by ch0", 32'(tick_o[0]), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule